// File: doc/BRIEF.md
# SDRAM Command Decoder with Mode Registers

This block sits on the command side of a synchronous DRAM model or monitor. On every rising clock it samples the chip select, row strobe, column strobe, write enable and clock enable pins together with the bank and address inputs. It reduces them to a single command, checks that command against the current state of the banks and the mode-register spacing rule, and reports the result one clock later as a one-hot vector plus a one-cycle illegal flag.

It also holds two mode registers. The bank address chosen during a mode-set command selects which of the two is written. The primary register gives burst length, burst ordering, read latency and the single-beat write option. The extended register gives the refreshed array fraction and the output drive strength. The decoded fields are exposed as outputs, so a data path or timing model can follow them. A command that breaks a rule is dropped: it changes neither the banks nor the registers.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: With cs_n low, {ras_n,cas_n,we_n} decodes as 000 mode set, 001 refresh, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge and 111 no-op. cs_n high is a no-op. The result appears on cmd_vec one clock after the sampling edge, with exactly one bit set. The bit positions are: 0 no-op, 1 mode set, 2 auto refresh, 3 self-refresh entry, 4 activate, 5 read, 6 write, 7 burst stop, 8 precharge.
- R2: A refresh is auto refresh (bit 2) when cke was high at the previous edge and is high now. It is self-refresh entry (bit 3) when cke was high at the previous edge and is low now. Any edge at which cke was low at the previous edge reports a no-op, and that no-op is not illegal. cke is taken as high at the first edge after reset.
- R3: A mode set with bank = 00 writes the primary register. A mode set with bank = 10 writes the extended register. A mode set with bank[0] = 1 is illegal. A written field shows on the outputs in the same cycle as the mode-set bit.
- R4: The primary register takes its fields from the address: addr[2:0] gives mr_burst_len, addr[3] gives mr_burst_type, addr[6:4] gives mr_cas_lat and addr[9] gives mr_single_write.
- R5: The extended register takes its fields from the address: addr[2:0] gives emr_pasr and addr[6:5] gives emr_drive. After reset every field of both registers is 0, which means full array and full drive strength.
- R6: Mode set, auto refresh and self-refresh entry are illegal while any bank is open.
- R7: In the MRD_CYC-1 cycles that follow an accepted mode set, any command other than a no-op is illegal. A command MRD_CYC cycles after the mode set is accepted.
- R8: An activate to an open bank is illegal, and so is a read or write to a closed bank. A precharge is always legal. A precharge with addr[10] = 1 closes every bank; with addr[10] = 0 it closes only the addressed bank.
- R9: A read or write with addr[10] = 1 closes its bank and starts a burst of N beats. Any read or write in the following N-1 cycles is illegal. A burst stop ends the lock. N is set by burst-length code 000→1, 001→2, 010→4, 011→8 and 111→PAGE_COLS; the other codes give 1. A write gives N = 1 when mr_single_write is set.
- R10: An illegal command raises illegal for exactly one cycle, reports the no-op bit, and changes no bank or register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all pins sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BANK_W | Bank address |
| addr | input | ADDR_W | Address / mode key |
| cmd_vec | output | 9 | One-hot decoded command |
| illegal | output | 1 | One-cycle flag for a rejected command |
| mr_burst_len | output | 3 | Burst length code |
| mr_burst_type | output | 1 | Burst ordering (0 sequential, 1 interleaved) |
| mr_cas_lat | output | 3 | Read latency code |
| mr_single_write | output | 1 | Writes use a single beat |
| emr_pasr | output | 3 | Refreshed array fraction code |
| emr_drive | output | 2 | Drive strength code |

## Verification
The bench builds the block with PAGE_COLS = 16 and MRD_CYC = 2 and keeps the extended register enabled. With the short page, the full-page auto-precharge lock and its early end by burst stop fit in a few cycles. With the two-cycle spacing, both the rejected command right after a mode set and the accepted one a cycle later are reachable. Default address and bank widths keep the real field positions and the reserved bank value under test.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   localparam int CMD_N = 9;
   localparam logic [3:0] C_NOP  = 4'd0;
   localparam logic [3:0] C_MRS  = 4'd1;
   localparam logic [3:0] C_AREF = 4'd2;
   localparam logic [3:0] C_SREF = 4'd3;
   localparam logic [3:0] C_ACT  = 4'd4;
   localparam logic [3:0] C_RD   = 4'd5;
   localparam logic [3:0] C_WR   = 4'd6;
   localparam logic [3:0] C_BST  = 4'd7;
   localparam logic [3:0] C_PRE  = 4'd8;

   typedef enum logic [2:0] {
      RAW_NOP, RAW_MRS, RAW_REF, RAW_ACT, RAW_RD, RAW_WR, RAW_BST, RAW_PRE
   } raw_cmd_e;

   function automatic int unsigned burst_beats(input logic [2:0] code, input int unsigned page);
      case (code)
         3'b000:  return 1;
         3'b001:  return 2;
         3'b010:  return 4;
         3'b011:  return 8;
         3'b111:  return page;
         default: return 1;
      endcase
   endfunction
endpackage

// File: rtl/sdc_pin_decode.sv
module sdc_pin_decode
   import sdc_pkg::*;
(
   input  logic     cs_n,
   input  logic     ras_n,
   input  logic     cas_n,
   input  logic     we_n,
   output raw_cmd_e raw_o
);
   always_comb begin
      if (cs_n) begin
         raw_o = RAW_NOP;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b000:  raw_o = RAW_MRS;
            3'b001:  raw_o = RAW_REF;
            3'b011:  raw_o = RAW_ACT;
            3'b101:  raw_o = RAW_RD;
            3'b100:  raw_o = RAW_WR;
            3'b110:  raw_o = RAW_BST;
            3'b010:  raw_o = RAW_PRE;
            default: raw_o = RAW_NOP;
         endcase
      end
   end
endmodule

// File: rtl/sdc_mode_regs.sv
module sdc_mode_regs #(
   parameter bit EXT_MR_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_main,
   input  logic       wr_ext,
   input  logic [9:0] key,
   output logic [2:0] burst_len,
   output logic       burst_type,
   output logic [2:0] cas_lat,
   output logic       single_write,
   output logic [2:0] pasr,
   output logic [1:0] drive
);
   logic unused_key;
   assign unused_key = ^key[8:7];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_len    <= '0;
         burst_type   <= 1'b0;
         cas_lat      <= '0;
         single_write <= 1'b0;
      end else if (wr_main) begin
         burst_len    <= key[2:0];
         burst_type   <= key[3];
         cas_lat      <= key[6:4];
         single_write <= key[9];
      end
   end

   generate
      if (EXT_MR_EN) begin : g_ext
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pasr  <= '0;
               drive <= '0;
            end else if (wr_ext) begin
               pasr  <= key[2:0];
               drive <= key[6:5];
            end
         end
         // R5
         ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_ext |=> ($stable(pasr) && $stable(drive)));
      end else begin : g_noext
         logic unused_wr_ext;
         assign unused_wr_ext = wr_ext;
         assign pasr  = '0;
         assign drive = '0;
      end
   endgenerate
endmodule

// File: rtl/sdc_bank_track.sv
module sdc_bank_track
   import sdc_pkg::*;
#(
   parameter int BANK_W  = 2,
   parameter int MRD_CYC = 2,
   parameter int CNT_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        cmd_id,
   input  logic [BANK_W-1:0] bank,
   input  logic              a10,
   input  logic [CNT_W-1:0]  beats_m1,
   output logic              ok_o
);
   localparam int NBANK = 1 << BANK_W;
   localparam int MRD_W = $clog2(MRD_CYC + 1);

   logic [NBANK-1:0] open_q;
   logic [CNT_W-1:0] ap_cnt;
   logic [MRD_W-1:0] mrd_cnt;
   logic             acc;
   logic             rdwr;

   assign rdwr = (cmd_id == C_RD) || (cmd_id == C_WR);

   always_comb begin
      ok_o = 1'b1;
      if (cmd_id != C_NOP && mrd_cnt != '0) ok_o = 1'b0;
      case (cmd_id)
         C_MRS:         if (|open_q || bank[0]) ok_o = 1'b0;
         C_AREF, C_SREF: if (|open_q) ok_o = 1'b0;
         C_ACT:         if (open_q[bank]) ok_o = 1'b0;
         C_RD, C_WR:    if (!open_q[bank] || ap_cnt != '0) ok_o = 1'b0;
         default: ;
      endcase
   end

   assign acc = ok_o && (cmd_id != C_NOP);

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               open_q[b] <= 1'b0;
            end else if (acc) begin
               if (cmd_id == C_ACT && bank == BANK_W'(b))
                  open_q[b] <= 1'b1;
               else if (cmd_id == C_PRE && (a10 || bank == BANK_W'(b)))
                  open_q[b] <= 1'b0;
               else if (rdwr && a10 && bank == BANK_W'(b))
                  open_q[b] <= 1'b0;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ap_cnt  <= '0;
         mrd_cnt <= '0;
      end else begin
         if (ap_cnt != '0) ap_cnt <= ap_cnt - 1'b1;
         if (mrd_cnt != '0) mrd_cnt <= mrd_cnt - 1'b1;
         if (acc && rdwr && a10) ap_cnt <= beats_m1;
         if (acc && cmd_id == C_BST) ap_cnt <= '0;
         if (acc && cmd_id == C_MRS) mrd_cnt <= MRD_W'(MRD_CYC - 1);
      end
   end

   // R7
   mrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_id == C_MRS && MRD_CYC > 1) |=> !acc);
   // R6
   refresh_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (cmd_id == C_AREF || cmd_id == C_SREF || cmd_id == C_MRS)) |-> (open_q == '0));
   // R9
   ap_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && rdwr && a10) |=> (ap_cnt == $past(beats_m1)));
endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
   import sdc_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int BANK_W    = 2,
   parameter int PAGE_COLS = 1024,
   parameter int MRD_CYC   = 2,
   parameter bit EXT_MR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BANK_W-1:0] bank,
   input  logic [ADDR_W-1:0] addr,
   output logic [CMD_N-1:0]  cmd_vec,
   output logic              illegal,
   output logic [2:0]        mr_burst_len,
   output logic              mr_burst_type,
   output logic [2:0]        mr_cas_lat,
   output logic              mr_single_write,
   output logic [2:0]        emr_pasr,
   output logic [1:0]        emr_drive
);
   localparam int CNT_W = $clog2(PAGE_COLS);

   generate
      if (ADDR_W < 11) begin : g_bad_addr
         $error("ADDR_W must be at least 11");
      end
      if (BANK_W != 2) begin : g_bad_bank
         $error("BANK_W must be 2");
      end
      if (MRD_CYC < 1 || PAGE_COLS < 8) begin : g_bad_timing
         $error("MRD_CYC >= 1 and PAGE_COLS >= 8 required");
      end
      if (ADDR_W > 11) begin : g_hi_addr
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:11];
      end
   endgenerate

   raw_cmd_e         raw;
   logic             cke_q;
   logic [3:0]       cmd_id;
   logic             ok;
   logic [CNT_W-1:0] beats_m1;
   int unsigned      beats;

   sdc_pin_decode u_dec (
      .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .raw_o (raw)
   );

   always_comb begin
      cmd_id = C_NOP;
      if (cke_q) begin
         case (raw)
            RAW_MRS: cmd_id = C_MRS;
            RAW_REF: cmd_id = cke ? C_AREF : C_SREF;
            RAW_ACT: cmd_id = C_ACT;
            RAW_RD:  cmd_id = C_RD;
            RAW_WR:  cmd_id = C_WR;
            RAW_BST: cmd_id = C_BST;
            RAW_PRE: cmd_id = C_PRE;
            default: cmd_id = C_NOP;
         endcase
      end
   end

   always_comb begin
      if (cmd_id == C_WR && mr_single_write) beats = 1;
      else beats = burst_beats(mr_burst_len, PAGE_COLS);
      beats_m1 = CNT_W'(beats - 1);
   end

   sdc_bank_track #(.BANK_W (BANK_W), .MRD_CYC (MRD_CYC), .CNT_W (CNT_W)) u_track (
      .clk (clk), .rst_n (rst_n), .cmd_id (cmd_id), .bank (bank),
      .a10 (addr[10]), .beats_m1 (beats_m1), .ok_o (ok)
   );

   sdc_mode_regs #(.EXT_MR_EN (EXT_MR_EN)) u_mr (
      .clk (clk), .rst_n (rst_n),
      .wr_main (ok && cmd_id == C_MRS && !bank[1]),
      .wr_ext  (ok && cmd_id == C_MRS && bank[1]),
      .key (addr[9:0]),
      .burst_len (mr_burst_len), .burst_type (mr_burst_type), .cas_lat (mr_cas_lat),
      .single_write (mr_single_write), .pasr (emr_pasr), .drive (emr_drive)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke_q   <= 1'b1;
         cmd_vec <= CMD_N'(1);
         illegal <= 1'b0;
      end else begin
         cke_q   <= cke;
         cmd_vec <= ok ? (CMD_N'(1) << cmd_id) : CMD_N'(1);
         illegal <= !ok;
      end
   end

   // R1
   onehot_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cmd_vec) == 1);
   // R10
   illegal_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (cmd_vec == CMD_N'(1)));
endmodule

// File: tb/sdram_cmd_decoder_tb.sv
module sdram_cmd_decoder_tb_top;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [8:0] vec;
      logic       ill;
      logic [9:0] nrm;
      logic [4:0] ext;
      string      tag;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1, cs_n = 1'b1;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  bank = '0;
   logic [12:0] addr = '0;
   logic [8:0]  cmd_vec;
   logic        illegal, mr_burst_type, mr_single_write;
   logic [2:0]  mr_burst_len, mr_cas_lat, emr_pasr;
   logic [1:0]  emr_drive;

   int checks = 0, fails = 0;
   bit done = 0;
   item_t q[$];
   logic [9:0] exp_nrm = '0;
   logic [4:0] exp_ext = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_cmd_decoder #(.PAGE_COLS (16), .MRD_CYC (2)) dut_i (
      .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
      .cas_n (cas_n), .we_n (we_n), .bank (bank), .addr (addr),
      .cmd_vec (cmd_vec), .illegal (illegal), .mr_burst_len (mr_burst_len),
      .mr_burst_type (mr_burst_type), .mr_cas_lat (mr_cas_lat),
      .mr_single_write (mr_single_write), .emr_pasr (emr_pasr), .emr_drive (emr_drive)
   );

   localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_ACT = 3'b011, P_RD = 3'b101,
                          P_WR = 3'b100, P_BST = 3'b110, P_PRE = 3'b010, P_NOP = 3'b111;

   function automatic logic [9:0] act_nrm();
      return {mr_single_write, 2'b00, mr_cas_lat, mr_burst_type, mr_burst_len};
   endfunction

   task automatic drive(input logic cs, input logic [2:0] rcw, input logic ck,
                        input logic [1:0] ba, input logic [12:0] ad,
                        input int exp_idx, input logic exp_ill, input string tag);
      item_t it;
      @(negedge clk);
      cs_n = cs; {ras_n, cas_n, we_n} = rcw; cke = ck; bank = ba; addr = ad;
      it.vec = 9'(1) << exp_idx; it.ill = exp_ill;
      it.nrm = exp_nrm; it.ext = exp_ext; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic nop();
      drive(1'b0, P_NOP, 1'b1, 2'b00, 13'h0, 0, 1'b0, "R1");
   endtask

   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         checks++;
         if (cmd_vec !== it.vec || illegal !== it.ill || act_nrm() !== it.nrm ||
             {emr_drive, emr_pasr} !== it.ext) begin
            fails++;
            $display("FAIL %s: vec=%b ill=%b nrm=%h ext=%h expected vec=%b ill=%b nrm=%h ext=%h",
                     it.tag, cmd_vec, illegal, act_nrm(), {emr_drive, emr_pasr},
                     it.vec, it.ill, it.nrm, it.ext);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (cmd_vec !== 9'd1 || illegal !== 1'b0 || act_nrm() !== 10'h0 ||
          {emr_drive, emr_pasr} !== 5'h0) begin
         fails++;
         $display("FAIL R5 reset: vec=%b ill=%b nrm=%h ext=%h expected vec=1 ill=0 nrm=0 ext=0",
                  cmd_vec, illegal, act_nrm(), {emr_drive, emr_pasr});
      end
      rst_n = 1'b1;
      // R1 deselect ignores strobes
      drive(1'b1, P_MRS, 1'b1, 2'b00, 13'h0, 0, 1'b0, "R1 deselect");
      // R3 R4 primary register: BL=4, interleave, CL=3
      exp_nrm = 10'h03A;
      drive(1'b0, P_MRS, 1'b1, 2'b00, 13'h03A, 1, 1'b0, "R4 mode set");
      drive(1'b0, P_ACT, 1'b1, 2'b01, 13'h0, 0, 1'b1, "R7 too soon");
      drive(1'b0, P_ACT, 1'b1, 2'b00, 13'h0, 4, 1'b0, "R7 spacing met");
      drive(1'b0, P_ACT, 1'b1, 2'b01, 13'h0, 4, 1'b0, "R1 activate");
      // R6 R10: rejected mode set leaves extended register alone
      drive(1'b0, P_MRS, 1'b1, 2'b10, 13'h022, 0, 1'b1, "R6 mode set open");
      drive(1'b0, P_REF, 1'b1, 2'b00, 13'h0, 0, 1'b1, "R6 refresh open");
      drive(1'b0, P_ACT, 1'b1, 2'b01, 13'h0, 0, 1'b1, "R8 activate open");
      drive(1'b0, P_RD, 1'b1, 2'b10, 13'h0, 0, 1'b1, "R8 read closed");
      // R9 auto-precharge read BL=4
      drive(1'b0, P_RD, 1'b1, 2'b01, 13'h400, 5, 1'b0, "R9 read ap");
      drive(1'b0, P_RD, 1'b1, 2'b00, 13'h0, 0, 1'b1, "R9 lock 1");
      nop();
      drive(1'b0, P_WR, 1'b1, 2'b00, 13'h0, 0, 1'b1, "R9 lock 3");
      drive(1'b0, P_RD, 1'b1, 2'b00, 13'h0, 5, 1'b0, "R9 lock over");
      drive(1'b0, P_WR, 1'b1, 2'b01, 13'h0, 0, 1'b1, "R9 bank closed by ap");
      drive(1'b0, P_PRE, 1'b1, 2'b00, 13'h0, 8, 1'b0, "R8 precharge one");
      drive(1'b0, P_REF, 1'b1, 2'b00, 13'h0, 2, 1'b0, "R2 auto refresh");
      // R3 R5 extended register: quarter array, half drive
      exp_ext = 5'b01_010;
      drive(1'b0, P_MRS, 1'b1, 2'b10, 13'h022, 1, 1'b0, "R5 ext mode set");
      nop();
      drive(1'b0, P_MRS, 1'b1, 2'b01, 13'h3FF, 0, 1'b1, "R3 reserved bank");
      // R4 full page, CL=2, single-beat writes
      exp_nrm = 10'h227;
      drive(1'b0, P_MRS, 1'b1, 2'b00, 13'h227, 1, 1'b0, "R4 full page");
      nop();
      drive(1'b0, P_ACT, 1'b1, 2'b11, 13'h0, 4, 1'b0, "R1 activate 3");
      drive(1'b0, P_WR, 1'b1, 2'b11, 13'h400, 6, 1'b0, "R9 single write ap");
      drive(1'b0, P_ACT, 1'b1, 2'b11, 13'h0, 4, 1'b0, "R9 no lock single write");
      drive(1'b0, P_RD, 1'b1, 2'b11, 13'h400, 5, 1'b0, "R9 full page ap");
      drive(1'b0, P_BST, 1'b1, 2'b00, 13'h0, 7, 1'b0, "R9 burst stop");
      drive(1'b0, P_ACT, 1'b1, 2'b10, 13'h0, 4, 1'b0, "R8 activate 2");
      drive(1'b0, P_RD, 1'b1, 2'b10, 13'h0, 5, 1'b0, "R9 lock ended by stop");
      drive(1'b0, P_PRE, 1'b1, 2'b00, 13'h400, 8, 1'b0, "R8 precharge all");
      drive(1'b0, P_REF, 1'b0, 2'b00, 13'h0, 3, 1'b0, "R2 self refresh entry");
      drive(1'b0, P_ACT, 1'b0, 2'b00, 13'h0, 0, 1'b0, "R2 cke low ignored");
      drive(1'b0, P_ACT, 1'b1, 2'b00, 13'h0, 0, 1'b0, "R2 cke was low");
      drive(1'b0, P_ACT, 1'b1, 2'b00, 13'h0, 4, 1'b0, "R2 resumed");
      nop();
      repeat (3) @(posedge clk);
      #3;
      finish_run();
   end
endmodule